// File: doc/BRIEF.md
# Self-Calibrating Wake-Up Timer Sequencer

This block keeps time for a sleeping radio. A slow, imprecise oscillator drives a wake-up counter. Now and then the block measures that oscillator against a precise reference oscillator, so the length of a timer unit stays close to a fixed number of reference periods whatever the slow clock's rate. Each period expiry gives a one-cycle wake-up event.

The first calibration runs right after reset. Later calibrations follow a fixed number of units after each one ends, whether or not the timer is enabled. For each calibration the block raises a request for the reference oscillator and waits until that oscillator reports that it is stable. It then measures and releases the request. In duty-cycled receive mode, every wake-up opens a receiver-enable window a programmable number of slow ticks long. A calibration that falls due while a window is open waits until the window closes.

All logic runs on one always-on logic clock. The slow clock, the reference clock and the reference-ready flag arrive asynchronously. The block synchronises them and detects their edges.

Top module: `wt_sequencer`

## Requirements
- R1: While `rst` is high, `wake_evt`, `rx_en`, `cal_busy` and `ref_req` are low. Within 4 clock cycles after `rst` falls, `cal_busy` and `ref_req` go high, even with `tmr_en` low.
- R2: `ref_req` is high exactly while `cal_busy` is high. The measurement does not start until `ref_ok` is high, so with `ref_ok` held low `cal_busy` stays high. Once measuring, a calibration ends after CAL_REF_EDGES rising reference edges, and `ref_req` falls with `cal_busy`.
- R3: A calibration counts slow-clock rising edges during its measurement window. That count, shifted left by DIV_SHIFT, becomes the number of slow ticks per timer unit. A unit therefore lasts about CAL_REF_EDGES << DIV_SHIFT reference periods at any slow-clock rate.
- R4: While `tmr_en` is high, `wake_evt` pulses high for one cycle every P units. P is `per_mant << per_exp`, and a mantissa of 0 counts as 1. While `tmr_en` is low there is no pulse.
- R5: Any change of `per_mant` or `per_exp` clears the unit and period counts. The next pulse comes one full new period after the change.
- R6: A new calibration starts CAL_EVERY_UNITS units after the previous one ended. This holds with the timer disabled.
- R7: With `dc_en` high, `rx_en` rises in the cycle after a `wake_evt` pulse. It falls after `rx_win` slow ticks, and a value of 0 counts as 1. Dropping `dc_en` closes the window. With `dc_en` low, `rx_en` stays low.
- R8: `cal_busy` never rises while `rx_en` is high. A calibration that falls due during a window starts within a few cycles after `rx_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on logic clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow timebase oscillator (asynchronous) |
| ref_clk | input | 1 | Precise reference oscillator (asynchronous) |
| ref_ok | input | 1 | Reference oscillator running and stable (asynchronous) |
| tmr_en | input | 1 | Wake-up timer enable |
| dc_en | input | 1 | Duty-cycled receive mode enable |
| per_mant | input | MANT_W | Period mantissa in units |
| per_exp | input | EXP_W | Period power-of-two exponent |
| rx_win | input | RXW_W | Receive window length in slow ticks |
| wake_evt | output | 1 | One-cycle wake-up event |
| ref_req | output | 1 | Request to run the reference oscillator |
| rx_en | output | 1 | Receiver enable |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The asynchronous inputs pass through two synchroniser stages and an edge register, so a slow or reference edge acts 2 to 3 cycles after it occurs. `wake_evt` is registered and appears one cycle after the slow tick that completes the period. `rx_en` follows `wake_evt` by exactly one cycle. `cal_busy` rises one cycle after a calibration becomes due and unblocked. The bench samples every output at the falling clock edge. It checks single-cycle relations (window opening, request tracking, start after a closed window) at the exact cycle. Intervals that depend on where slow edges fall are checked against windows of about ten percent around the unit length, which a scoreboard queue holds for each expected wake-up.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // Width of the slow-tick-per-unit divider and of the calibration count
    localparam int unsigned WT_DIV_W = 16;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_WAIT_REF,
        CAL_MEASURE,
        CAL_APPLY
    } cal_state_e;

    typedef struct packed {
        logic                valid;
        logic [WT_DIV_W-1:0] div;
    } cal_result_t;

    // Scaled measurement, never zero so a unit always spans at least one tick
    function automatic logic [WT_DIV_W-1:0] scale_ticks(
        input logic [WT_DIV_W-1:0] ticks,
        input int unsigned         shift
    );
        logic [WT_DIV_W-1:0] s;
        s = ticks << shift;
        return (s == '0) ? WT_DIV_W'(1) : s;
    endfunction

endpackage

// File: rtl/wt_edge_sync.sv
module wt_edge_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          EDGE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= 1'b0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= 1'b0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    if (EDGE) begin : g_rise
        logic last;
        always_ff @(posedge clk) begin
            if (rst) last <= 1'b0;
            else     last <= stg[STAGES-1];
        end
        assign q = stg[STAGES-1] & ~last;
    end else begin : g_level
        assign q = stg[STAGES-1];
    end

endmodule

// File: rtl/wt_cal.sv
module wt_cal
    import wt_pkg::*;
#(
    parameter int unsigned CAL_REF_EDGES   = 5000,
    parameter int unsigned DIV_SHIFT       = 1,
    parameter int unsigned CAL_EVERY_UNITS = 30000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic        ref_tick,
    input  logic        ref_ok,
    input  logic        unit_tick,
    input  logic        hold_off,
    output logic        busy,
    output cal_result_t result
);

    localparam int unsigned REF_CNT_W = $clog2(CAL_REF_EDGES + 1);
    localparam int unsigned IVL_W     = $clog2(CAL_EVERY_UNITS + 1);
    localparam logic [REF_CNT_W-1:0] REF_LAST = REF_CNT_W'(CAL_REF_EDGES - 1);
    localparam logic [IVL_W-1:0]     IVL_LAST = IVL_W'(CAL_EVERY_UNITS - 1);

    cal_state_e           state;
    logic                 pending;
    logic [REF_CNT_W-1:0] ref_cnt;
    logic [WT_DIV_W-1:0]  slow_cnt;
    logic [IVL_W-1:0]     ivl_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAL_IDLE;
            pending  <= 1'b1;
            result   <= '{valid: 1'b0, div: WT_DIV_W'(1)};
            ref_cnt  <= '0;
            slow_cnt <= '0;
            ivl_cnt  <= '0;
        end else begin
            case (state)
                CAL_IDLE: begin
                    if (pending && !hold_off) begin
                        state   <= CAL_WAIT_REF;
                        pending <= 1'b0;
                    end else if (result.valid && !pending && unit_tick) begin
                        if (ivl_cnt == IVL_LAST) begin
                            pending <= 1'b1;
                            ivl_cnt <= '0;
                        end else begin
                            ivl_cnt <= ivl_cnt + 1'b1;
                        end
                    end
                end
                CAL_WAIT_REF: begin
                    if (ref_ok) begin
                        state    <= CAL_MEASURE;
                        ref_cnt  <= '0;
                        slow_cnt <= '0;
                    end
                end
                CAL_MEASURE: begin
                    if (slow_tick && (slow_cnt != '1)) slow_cnt <= slow_cnt + 1'b1;
                    if (ref_tick) begin
                        if (ref_cnt == REF_LAST) state <= CAL_APPLY;
                        else                     ref_cnt <= ref_cnt + 1'b1;
                    end
                end
                CAL_APPLY: begin
                    result.div   <= scale_ticks(slow_cnt, DIV_SHIFT);
                    result.valid <= 1'b1;
                    ivl_cnt      <= '0;
                    state        <= CAL_IDLE;
                end
                default: state <= CAL_IDLE;
            endcase
        end
    end

    assign busy = (state != CAL_IDLE);

endmodule

// File: rtl/wt_period.sv
module wt_period
    import wt_pkg::*;
#(
    parameter int unsigned MANT_W = 8,
    parameter int unsigned EXP_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slow_tick,
    input  cal_result_t         cal,
    input  logic                tmr_en,
    input  logic [MANT_W-1:0]   per_mant,
    input  logic [EXP_W-1:0]    per_exp,
    output logic                unit_tick,
    output logic                wake
);

    localparam int unsigned PER_W = MANT_W + (1 << EXP_W) - 1;

    logic [MANT_W+EXP_W-1:0] prev_set;
    logic                    changed;
    logic [WT_DIV_W-1:0]     tick_cnt;
    logic [PER_W-1:0]        per_cnt;
    logic [MANT_W-1:0]       eff_mant;
    logic [PER_W-1:0]        target;
    logic                    unit_end;
    logic                    per_end;

    assign changed   = ({per_mant, per_exp} != prev_set);
    assign eff_mant  = (per_mant == '0) ? MANT_W'(1) : per_mant;
    assign target    = PER_W'(eff_mant) << per_exp;
    assign unit_end  = (tick_cnt >= (cal.div - 1'b1));
    assign unit_tick = cal.valid && !changed && slow_tick && unit_end;
    assign per_end   = (per_cnt == (target - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) prev_set <= '0;
        else     prev_set <= {per_mant, per_exp};
    end

    // Slow ticks inside the current unit
    always_ff @(posedge clk) begin
        if (rst || !cal.valid || changed) begin
            tick_cnt <= '0;
        end else if (slow_tick) begin
            tick_cnt <= unit_end ? '0 : tick_cnt + 1'b1;
        end
    end

    // Units inside the current period
    always_ff @(posedge clk) begin
        if (rst || !tmr_en || changed || !cal.valid) begin
            per_cnt <= '0;
        end else if (unit_tick) begin
            per_cnt <= per_end ? '0 : per_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wake <= 1'b0;
        else     wake <= tmr_en && unit_tick && per_end;
    end

endmodule

// File: rtl/wt_duty.sv
module wt_duty #(
    parameter int unsigned RXW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dc_en,
    input  logic             wake,
    input  logic             slow_tick,
    input  logic [RXW_W-1:0] rx_win,
    output logic             rx_open
);

    logic [RXW_W-1:0] win_cnt;
    logic [RXW_W-1:0] eff_win;

    assign eff_win = (rx_win == '0) ? RXW_W'(1) : rx_win;

    always_ff @(posedge clk) begin
        if (rst || !dc_en) begin
            rx_open <= 1'b0;
            win_cnt <= '0;
        end else if (wake) begin
            rx_open <= 1'b1;
            win_cnt <= '0;
        end else if (rx_open && slow_tick) begin
            if (win_cnt == (eff_win - 1'b1)) rx_open <= 1'b0;
            else                            win_cnt <= win_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wt_sequencer.sv
module wt_sequencer
    import wt_pkg::*;
#(
    parameter int unsigned MANT_W          = 8,
    parameter int unsigned EXP_W           = 5,
    parameter int unsigned RXW_W           = 8,
    parameter int unsigned CAL_REF_EDGES   = 5000,
    parameter int unsigned DIV_SHIFT       = 1,
    parameter int unsigned CAL_EVERY_UNITS = 30000,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              ref_clk,
    input  logic              ref_ok,
    input  logic              tmr_en,
    input  logic              dc_en,
    input  logic [MANT_W-1:0] per_mant,
    input  logic [EXP_W-1:0]  per_exp,
    input  logic [RXW_W-1:0]  rx_win,
    output logic              wake_evt,
    output logic              ref_req,
    output logic              rx_en,
    output logic              cal_busy
);

    // Index 0: slow clock edge, 1: reference clock edge, 2: reference ready level
    localparam int unsigned N_ASYNC   = 3;
    localparam logic [2:0]  EDGE_MASK = 3'b011;

    logic        raw [N_ASYNC];
    logic        syn [N_ASYNC];
    cal_result_t cal_res;
    logic        unit_tick;
    logic        busy;
    logic        wake;
    logic        rx_open;

    assign raw[0] = slow_clk;
    assign raw[1] = ref_clk;
    assign raw[2] = ref_ok;

    for (genvar k = 0; k < N_ASYNC; k++) begin : g_sync
        wt_edge_sync #(
            .STAGES (SYNC_STAGES),
            .EDGE   (EDGE_MASK[k])
        ) i_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[k]),
            .q   (syn[k])
        );
    end

    wt_cal #(
        .CAL_REF_EDGES   (CAL_REF_EDGES),
        .DIV_SHIFT       (DIV_SHIFT),
        .CAL_EVERY_UNITS (CAL_EVERY_UNITS)
    ) i_cal (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (syn[0]),
        .ref_tick  (syn[1]),
        .ref_ok    (syn[2]),
        .unit_tick (unit_tick),
        .hold_off  (rx_open || (wake && dc_en)),
        .busy      (busy),
        .result    (cal_res)
    );

    wt_period #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) i_period (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (syn[0]),
        .cal       (cal_res),
        .tmr_en    (tmr_en),
        .per_mant  (per_mant),
        .per_exp   (per_exp),
        .unit_tick (unit_tick),
        .wake      (wake)
    );

    wt_duty #(
        .RXW_W (RXW_W)
    ) i_duty (
        .clk       (clk),
        .rst       (rst),
        .dc_en     (dc_en),
        .wake      (wake),
        .slow_tick (syn[0]),
        .rx_win    (rx_win),
        .rx_open   (rx_open)
    );

    assign wake_evt = wake;
    assign rx_en    = rx_open;
    assign cal_busy = busy;
    assign ref_req  = busy;

endmodule

// File: rtl/wt_sequencer_checker.sv
module wt_sequencer_checker (
    input logic clk,
    input logic rst,
    input logic tmr_en,
    input logic dc_en,
    input logic ref_ok,
    input logic wake_evt,
    input logic ref_req,
    input logic rx_en,
    input logic cal_busy
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!wake_evt && !rx_en));

    assert_ref_drop_after_ready_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_req) |-> $past(ref_ok));

    assert_wake_single_R4: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> !wake_evt);

    assert_wake_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> $past(tmr_en));

    assert_rx_opens_on_wake_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en) |-> ($past(wake_evt) && $past(dc_en)));

    assert_cal_deferred_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_busy) |-> !rx_en);

endmodule

bind wt_sequencer wt_sequencer_checker i_wt_chk (
    .clk      (clk),
    .rst      (rst),
    .tmr_en   (tmr_en),
    .dc_en    (dc_en),
    .ref_ok   (ref_ok),
    .wake_evt (wake_evt),
    .ref_req  (ref_req),
    .rx_en    (rx_en),
    .cal_busy (cal_busy)
);

// File: tb/test_wt_sequencer.sv
`timescale 1ns/1ps
module test_wt_sequencer;

    localparam int MANT_W = 8;
    localparam int EXP_W  = 4;
    localparam int RXW_W  = 8;
    localparam int UNIT   = 400;   // nominal unit: 50 ref edges * 2 * 40 ns / 10 ns

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              slow_clk = 1'b0;
    logic              ref_clk = 1'b0;
    logic              ref_ok;
    logic              tmr_en = 1'b0;
    logic              dc_en = 1'b0;
    logic [MANT_W-1:0] per_mant = '0;
    logic [EXP_W-1:0]  per_exp = '0;
    logic [RXW_W-1:0]  rx_win = '0;
    logic              wake_evt, ref_req, rx_en, cal_busy;

    int  slow_half = 50;
    bit  osc_broken = 1'b0;
    logic osc_run;
    int  settle = 0;
    int  cyc = 0;

    int n_checks = 0, n_fails = 0;
    int mon_checks = 0, mon_fails = 0;
    bit wd_fail = 1'b0;
    int drv_mark = 0;
    int mon_mark = 0;

    typedef struct {
        string tag;
        int    lo;
        int    hi;
    } exp_t;
    exp_t sb_q[$];

    wt_sequencer #(
        .MANT_W (MANT_W), .EXP_W (EXP_W), .RXW_W (RXW_W),
        .CAL_REF_EDGES (50), .DIV_SHIFT (1), .CAL_EVERY_UNITS (6), .SYNC_STAGES (2)
    ) i_wt_sequencer (
        .clk (clk), .rst (rst), .slow_clk (slow_clk), .ref_clk (ref_clk),
        .ref_ok (ref_ok), .tmr_en (tmr_en), .dc_en (dc_en),
        .per_mant (per_mant), .per_exp (per_exp), .rx_win (rx_win),
        .wake_evt (wake_evt), .ref_req (ref_req), .rx_en (rx_en), .cal_busy (cal_busy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        #(slow_half);
        slow_clk = ~slow_clk;
    end

    // Reference oscillator model: runs on request, ready after 10 cycles
    assign osc_run = ref_req && !osc_broken;
    always @(posedge clk) begin
        if (!osc_run)        settle <= 0;
        else if (settle < 10) settle <= settle + 1;
    end
    assign ref_ok = osc_run && (settle == 10);
    initial forever begin
        #20;
        if (osc_run) ref_clk = ~ref_clk;
        else         ref_clk = 1'b0;
    end

    // Scoreboard monitor: compares each wake interval against the queued window
    always @(negedge clk) begin
        if (!rst && wake_evt) begin
            if (sb_q.size() > 0) begin
                exp_t e;
                int   iv;
                e  = sb_q.pop_front();
                iv = cyc - ((drv_mark > mon_mark) ? drv_mark : mon_mark);
                mon_checks++;
                if (iv < e.lo || iv > e.hi) begin
                    mon_fails++;
                    $display("FAIL %s: wake interval actual %0d expected %0d..%0d",
                             e.tag, iv, e.lo, e.hi);
                end
            end
            mon_mark = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_wake(input string tag, input int units, input int pct);
        exp_t e;
        e.tag = tag;
        e.lo  = units * UNIT * (100 - pct) / 100;
        e.hi  = units * UNIT * (100 + pct) / 100;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    task automatic set_period(input int m, input int e);
        per_mant = MANT_W'(m);
        per_exp  = EXP_W'(e);
        drv_mark = cyc;
    endtask

    task automatic wait_cal_done();
        while (!cal_busy) @(negedge clk);
        while (cal_busy)  @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_checks + mon_checks + (wd_fail ? 1 : 0),
                 n_fails + mon_fails + (wd_fail ? 1 : 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_fail = 1'b1;
        $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
        summary();
        $finish;
    end

    initial begin
        int len, cnt, rises;
        bit prev;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(!wake_evt && !rx_en && !cal_busy && !ref_req, "R1", "outputs in reset",
              {wake_evt, rx_en, cal_busy, ref_req}, 0);
        rst = 1'b0;
        cnt = 0;
        while (!cal_busy && cnt < 10) begin @(negedge clk); cnt++; end
        check(cal_busy && cnt <= 4, "R1", "cycles to startup calibration", cnt, 4);
        check(ref_req == cal_busy, "R2", "ref_req tracks cal_busy", ref_req, cal_busy);

        // R2: calibration length with the oscillator started on request
        len = 0;
        while (cal_busy) begin @(negedge clk); len++; end
        check(len >= 200 && len <= 240, "R2", "calibration cycles", len, 220);
        check(!ref_req, "R2", "ref_req after calibration", ref_req, 0);

        // R6 and R4: periodic recalibration while asleep, no wake-up
        len = 0; cnt = 0;
        while (!cal_busy) begin
            @(negedge clk); len++;
            if (wake_evt) cnt++;
        end
        check(len >= 6*UNIT*90/100 && len <= 6*UNIT*110/100, "R6",
              "cycles between calibrations in sleep", len, 6*UNIT);
        check(cnt == 0, "R4", "wake-ups with timer disabled", cnt, 0);
        while (cal_busy) @(negedge clk);

        // R4 and R5: periodic wake-ups, restart on setting change
        tmr_en = 1'b1;
        set_period(3, 1);
        expect_wake("R5", 6, 10);
        expect_wake("R4", 6, 10);
        expect_wake("R4", 6, 10);
        drain();

        // R5: change in mid-period restarts the count
        repeat (3*UNIT) @(negedge clk);
        set_period(2, 0);
        expect_wake("R5", 2, 10);
        drain();

        // R4: mantissa 0 counts as 1
        set_period(0, 2);
        expect_wake("R4", 4, 10);
        expect_wake("R4", 4, 10);
        drain();

        // R3: unit length from calibration at two slow-clock rates
        set_period(1, 0);
        expect_wake("R3", 1, 10);
        expect_wake("R3", 1, 10);
        drain();
        slow_half = 75;
        wait_cal_done();
        set_period(2, 0);
        expect_wake("R3", 2, 12);
        expect_wake("R3", 2, 12);
        drain();
        slow_half = 50;
        wait_cal_done();

        // R7: duty-cycled receive window
        set_period(1, 0);
        rx_win = 8'd5;
        dc_en = 1'b1;
        @(negedge clk);
        while (!wake_evt) @(negedge clk);
        @(negedge clk);
        check(rx_en, "R7", "rx_en the cycle after wake", rx_en, 1);
        len = 0;
        while (rx_en) begin @(negedge clk); len++; end
        check(len >= 38 && len <= 56, "R7", "window cycles for 5 ticks", len, 47);
        rx_win = 8'd0;
        while (!wake_evt) @(negedge clk);
        @(negedge clk);
        len = 0;
        while (rx_en) begin @(negedge clk); len++; end
        check(len >= 1 && len <= 12, "R7", "window cycles for value 0", len, 6);
        dc_en = 1'b0;
        cnt = 0;
        repeat (3*UNIT) begin @(negedge clk); if (rx_en) cnt++; end
        check(cnt == 0, "R7", "rx_en cycles with mode off", cnt, 0);

        // R8: calibration held off while the window stays open
        rx_win = 8'd255;
        dc_en = 1'b1;
        while (!rx_en) @(negedge clk);
        rises = 0; prev = cal_busy;
        repeat (5000) begin
            @(negedge clk);
            if (cal_busy && !prev && rx_en) rises++;
            prev = cal_busy;
        end
        check(rises == 0, "R8", "calibration starts during window", rises, 0);
        check(!cal_busy, "R8", "cal_busy while window open", cal_busy, 0);
        dc_en = 1'b0;
        cnt = 0;
        while (!cal_busy && cnt < 20) begin @(negedge clk); cnt++; end
        check(cal_busy && cnt <= 5, "R8", "cycles to deferred start", cnt, 3);
        while (cal_busy) @(negedge clk);

        // R2: measurement waits for the ready flag
        osc_broken = 1'b1;
        while (!cal_busy) @(negedge clk);
        repeat (1000) @(negedge clk);
        check(cal_busy && ref_req, "R2", "busy and request with no ready",
              {cal_busy, ref_req}, 3);
        osc_broken = 1'b0;
        len = 0;
        while (cal_busy && len < 1000) begin @(negedge clk); len++; end
        check(len >= 200 && len <= 240, "R2", "cycles to finish after ready", len, 220);
        check(!ref_req, "R2", "ref_req released", ref_req, 0);

        // R4: disabling stops wake-ups
        tmr_en = 1'b0;
        @(negedge clk);
        cnt = 0;
        repeat (4*UNIT) begin @(negedge clk); if (wake_evt) cnt++; end
        check(cnt == 0, "R4", "wake-ups after disable", cnt, 0);

        summary();
        $finish;
    end

endmodule